// File: doc/BRIEF.md
# Carry-Save Feedback Queue with Word-Serial Resolution

This block closes the loop between the last and the first processing element of a word-serial, pipelined modular multiplier kernel. Each cycle the last element may hand over one W-bit word of the partial result as a carry-save pair: a sum vector and a carry vector. The value the pair stands for is sum + 2·carry. The first element takes one W-bit pair per cycle. A three-way selector chooses what it receives: an all-zero word for the opening pass, the incoming pair passed straight through, or a word taken from a queue.

Every accepted word goes through a word-serial carry-propagate adder, which turns it into one plain binary word. A registered carry links each word to the next, and that carry is cleared at word 0 of a pass. A word that cannot be bypassed is stored in its resolved form, so each queue entry holds W bits instead of 2W. All resolved words also leave the block as the result stream. The pair is bypassed only when the queue is empty and the first element can take it. That way queued words keep their order, and a bypassed word does not wait on the adder.

Top module: `csq_feedback`

## Requirements
- R1: After a synchronous reset with no request pending, empty=1, full=0, err=0, res_valid=0 and out_valid=0.
- R2: While zero_req is high, out_valid=1, out_sum=0, out_carry=0 and out_src=0 (zero), whatever else is driven.
- R3: When zero_req is low, the queue is empty, out_ready is high and in_valid is high, the incoming pair appears unchanged on out_sum/out_carry in the same cycle with out_src=1 (bypass), in_ready=1, and the word is not stored (empty stays 1).
- R4: An accepted word that is not bypassed is stored as its resolved W-bit word. While the queue holds words and zero_req is low, the oldest word is offered on out_sum with out_carry=0 and out_src=2 (queue), and words leave in arrival order, one per cycle with out_ready high.
- R5: The resolved word is the low W bits of sum + 2·carry + cin. cin is 0 when in_first is high; otherwise it is the bits above W (0 to 2) left over from the previous accepted word.
- R6: Every accepted word (in_valid and in_ready) gives res_valid=1 with its resolved word on res_word exactly one cycle later; otherwise res_valid=0.
- R7: full goes high once DEPTH words are stored, and in_ready is then low.
- R8: in_valid while in_ready is low sets err, which stays set until reset. The word is dropped: nothing is stored, the carry does not advance and res_valid stays low.
- R9: While the queue holds words, an incoming pair is never bypassed. It is queued behind them, even in a cycle in which a queued word leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_req | input | 1 | Feed a zero word to the first element (opening pass) |
| in_valid | input | 1 | Carry-save word offered by the last element |
| in_ready | output | 1 | Offered word is taken this cycle |
| in_first | input | 1 | Offered word is word 0 of its pass (clears carry-in) |
| in_sum | input | W | Sum vector of the offered word |
| in_carry | input | W | Carry vector of the offered word (weight 2) |
| out_valid | output | 1 | A word is presented to the first element |
| out_ready | input | 1 | First element takes the presented word |
| out_sum | output | W | Sum vector to the first element |
| out_carry | output | W | Carry vector to the first element |
| out_src | output | 2 | Selected source: 0 zero, 1 bypass, 2 queue |
| res_valid | output | 1 | Resolved result word valid |
| res_word | output | W | Resolved binary result word |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| err | output | 1 | Sticky overflow flag |

## Verification
Selector outputs and in_ready are combinational, so the bench checks them about 1 ns after it drives the inputs at the falling edge, before the next rising edge. The resolved word goes through one register, so the bench checks res_valid and res_word at the falling edge after the accepting rising edge. The flags (full, empty, err) and the queue head reflect a push or pop from the next rising edge on, so the bench checks them in the falling-edge half that follows. The carry chain is tested with words that carry out 0, 1 and 2 and with in_first clearing a pending carry. The expected words are worked out by hand from R5.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_QUEUE  = 2'd2
  } zsrc_e;
endpackage

// File: rtl/csq_cpa.sv
// Word-serial carry-propagate adder: resolves sum + 2*carry + cin.
module csq_cpa #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         first,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] carry,
  output logic [W-1:0] word,
  output logic         res_valid,
  output logic [W-1:0] res_word
);
  localparam int SW = W + 2;

  logic [1:0]    cy_q;
  logic [1:0]    cin;
  logic [SW-1:0] total;

  always_comb begin
    cin   = first ? 2'd0 : cy_q;
    total = {2'b00, sum} + {1'b0, carry, 1'b0} + {{W{1'b0}}, cin};
    word  = total[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q      <= 2'd0;
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= step;
      if (step) begin
        cy_q     <= total[SW-1:W];
        res_word <= total[W-1:0];
      end
    end
  end
endmodule

// File: rtl/csq_fifo.sv
// Resolved-word queue, W bits per entry, storage without reset.
module csq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CMAX);
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/csq_sel.sv
// Three-way source selector for the first processing element.
module csq_sel #(
  parameter int W = 32
) (
  input  logic             zero_req,
  input  logic             q_avail,
  input  logic [W-1:0]     q_word,
  input  logic             in_valid,
  input  logic [W-1:0]     in_sum,
  input  logic [W-1:0]     in_carry,
  output logic             out_valid,
  output logic [W-1:0]     out_sum,
  output logic [W-1:0]     out_carry,
  output csq_pkg::zsrc_e   src
);
  always_comb begin
    if (zero_req) begin
      src       = csq_pkg::SRC_ZERO;
      out_valid = 1'b1;
      out_sum   = '0;
      out_carry = '0;
    end else if (q_avail) begin
      src       = csq_pkg::SRC_QUEUE;
      out_valid = 1'b1;
      out_sum   = q_word;
      out_carry = '0;
    end else begin
      src       = csq_pkg::SRC_BYPASS;
      out_valid = in_valid;
      out_sum   = in_sum;
      out_carry = in_carry;
    end
  end
endmodule

// File: rtl/csq_feedback.sv
module csq_feedback #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero_req,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_first,
  input  logic [W-1:0] in_sum,
  input  logic [W-1:0] in_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sum,
  output logic [W-1:0] out_carry,
  output logic [1:0]   out_src,
  output logic         res_valid,
  output logic [W-1:0] res_word,
  output logic         full,
  output logic         empty,
  output logic         err
);
  logic           byp_ok, bypass, accept, push, pop;
  logic [W-1:0]   resolved, q_word;
  csq_pkg::zsrc_e src;

  assign byp_ok   = !zero_req && empty && out_ready;
  assign in_ready = byp_ok || !full;
  assign bypass   = in_valid && byp_ok;
  assign accept   = in_valid && in_ready;
  assign push     = accept && !bypass;
  assign pop      = out_ready && !zero_req && !empty;
  assign out_src  = src;

  csq_cpa #(.W(W)) u_cpa (
    .clk(clk), .rst(rst), .step(accept), .first(in_first),
    .sum(in_sum), .carry(in_carry), .word(resolved),
    .res_valid(res_valid), .res_word(res_word)
  );

  csq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(resolved), .pop(pop),
    .dout(q_word), .full(full), .empty(empty)
  );

  csq_sel #(.W(W)) u_sel (
    .zero_req(zero_req), .q_avail(!empty), .q_word(q_word),
    .in_valid(in_valid), .in_sum(in_sum), .in_carry(in_carry),
    .out_valid(out_valid), .out_sum(out_sum), .out_carry(out_carry),
    .src(src)
  );

  always_ff @(posedge clk) begin
    if (rst)                         err <= 1'b0;
    else if (in_valid && !in_ready)  err <= 1'b1;
  end
endmodule

// File: rtl/csq_feedback_chk.sv
module csq_feedback_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         zero_req,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_sum,
  input logic [W-1:0] in_carry,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sum,
  input logic [W-1:0] out_carry,
  input logic [1:0]   out_src,
  input logic         res_valid,
  input logic         full,
  input logic         empty,
  input logic         err
);
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    zero_req |-> (out_valid && out_sum == '0 && out_carry == '0)); // R2
  AST_BYPASS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!zero_req && empty && in_valid) |-> (out_valid && out_sum == in_sum && out_carry == in_carry)); // R3
  AST_QUEUE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!zero_req && !empty) |-> (out_valid && out_carry == '0)); // R4
  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> res_valid); // R6
  AST_NO_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !res_valid); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    full |-> !in_ready); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> err); // R8
  AST_QUEUE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!zero_req && !empty) |-> (out_src == 2'd2)); // R9
endmodule

bind csq_feedback csq_feedback_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .zero_req(zero_req), .in_valid(in_valid),
  .in_ready(in_ready), .in_sum(in_sum), .in_carry(in_carry),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
  .out_carry(out_carry), .out_src(out_src), .res_valid(res_valid),
  .full(full), .empty(empty), .err(err)
);

// File: tb/sim_csq_feedback.sv
`timescale 1ns/1ps
module sim_csq_feedback;
  localparam int W = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zero_req = 1'b0, in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_sum = '0, in_carry = '0;
  logic in_ready, out_valid, res_valid, full, empty, err;
  logic [W-1:0] out_sum, out_carry, res_word;
  logic [1:0] out_src;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  csq_feedback #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .zero_req(zero_req), .in_valid(in_valid),
    .in_ready(in_ready), .in_first(in_first), .in_sum(in_sum),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_carry(out_carry), .out_src(out_src),
    .res_valid(res_valid), .res_word(res_word), .full(full),
    .empty(empty), .err(err)
  );

  // {first, sum, carry, expected resolved word}
  localparam logic [24:0] VEC [0:9] = '{
    {1'b1, 8'h0B, 8'h05, 8'h15},
    {1'b1, 8'hFF, 8'hFF, 8'hFD},
    {1'b0, 8'h00, 8'h00, 8'h02},
    {1'b0, 8'h80, 8'h40, 8'h00},
    {1'b0, 8'h01, 8'h00, 8'h02},
    {1'b1, 8'hF0, 8'h88, 8'h00},
    {1'b1, 8'h12, 8'h34, 8'h7A},
    {1'b0, 8'hFF, 8'h80, 8'hFF},
    {1'b0, 8'hFF, 8'hFF, 8'hFE},
    {1'b0, 8'h00, 8'h00, 8'h02}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  task automatic offer(input logic f, input logic [W-1:0] s, input logic [W-1:0] c);
    in_valid = 1'b1; in_first = f; in_sum = s; in_carry = c;
  endtask

  task automatic idle_in();
    in_valid = 1'b0; in_first = 1'b0; in_sum = '0; in_carry = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

    // R2 zero word for the opening pass
    @(negedge clk);
    zero_req = 1'b1; out_ready = 1'b1;
    #1;
    chk(out_valid && out_sum == 0 && out_carry == 0, "R2 zero word",
        {out_sum, out_carry}, 0);
    chk(out_src == 2'd0, "R2 src", out_src, 0);
    @(negedge clk);
    zero_req = 1'b0;

    // R3/R5/R6 table walk through the bypass path
    for (int i = 0; i < 10; i++) begin
      offer(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      #1;
      chk(out_valid && out_sum == VEC[i][23:16] && out_carry == VEC[i][15:8],
          "R3 bypass pair", {out_sum, out_carry}, VEC[i][23:8]);
      chk(out_src == 2'd1 && in_ready, "R3 bypass src/ready", {in_ready, out_src}, 3'b101);
      @(negedge clk);
      idle_in();
      #1;
      chk(res_valid && res_word == VEC[i][7:0], "R5 R6 resolved word",
          {res_valid, res_word}, {1'b1, VEC[i][7:0]});
      chk(empty == 1'b1, "R3 not stored", empty, 1);
      @(negedge clk);
    end

    // R4/R7 fill the queue with the first element busy
    out_ready = 1'b0;
    offer(1'b1, 8'h10, 8'h08); @(negedge clk);
    offer(1'b0, 8'h03, 8'h01); @(negedge clk);
    offer(1'b0, 8'hFF, 8'h7F); @(negedge clk);
    offer(1'b0, 8'h00, 8'h00); @(negedge clk);
    idle_in();
    #1;
    chk(full == 1'b1 && in_ready == 1'b0, "R7 full blocks", {full, in_ready}, 2'b10);
    chk(res_valid && res_word == 8'h01, "R5 carry-in of one", res_word, 8'h01);

    // R8 overflow: dropped, error sticks
    offer(1'b0, 8'h55, 8'h55);
    @(negedge clk);
    idle_in();
    #1;
    chk(err == 1'b1, "R8 err set", err, 1);
    chk(res_valid == 1'b0, "R8 no result", res_valid, 0);

    // R4 drain in order, R9 arrival during drain is queued
    out_ready = 1'b1;
    #1;
    chk(out_sum == 8'h20 && out_carry == 0 && out_src == 2'd2, "R4 head 0",
        {out_src, out_sum, out_carry}, {2'd2, 8'h20, 8'h00});
    @(negedge clk);
    offer(1'b1, 8'h33, 8'h00);
    #1;
    chk(out_src == 2'd2 && out_sum == 8'h05, "R9 queued word has priority",
        {out_src, out_sum}, {2'd2, 8'h05});
    chk(in_ready == 1'b1, "R9 accepted into queue", in_ready, 1);
    @(negedge clk);
    idle_in();
    #1;
    chk(out_sum == 8'hFD && out_carry == 0, "R4 head 2", out_sum, 8'hFD);
    @(negedge clk);
    #1;
    chk(out_sum == 8'h01 && out_src == 2'd2, "R4 head 3", out_sum, 8'h01);
    @(negedge clk);
    #1;
    chk(out_sum == 8'h33 && out_src == 2'd2, "R9 late word last", out_sum, 8'h33);
    @(negedge clk);
    #1;
    chk(empty == 1'b1 && out_valid == 1'b0, "R4 drained", {empty, out_valid}, 2'b10);
    chk(err == 1'b1, "R8 err sticky", err, 1);

    // R1 reset clears the sticky error
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b0;
    #1;
    chk(err == 1'b0 && empty == 1'b1, "R1 reset after error", {err, empty}, 2'b01);

    finish_run();
  end
endmodule